// File: doc/BRIEF.md
# Trap and Interrupt Annulment Controller

This controller sits beside the instruction registers of a five-stage pipeline (fetch, register read, ALU, memory, write-back) and decides, every cycle, what each of the first four stages carries forward. Each stage's instruction register has a three-way input. It can keep the instruction, replace it with a no-op, or replace it with a synthetic conditional branch. That branch never jumps, but it does write its own PC+4 into the exception-pointer register when it reaches write-back. The controller also picks where the next fetch comes from: the sequential path, the trap vector or the interrupt vector.

Three kinds of synchronous event are recognised. An undefined opcode is found in register read, an arithmetic fault is raised in the ALU stage and a memory fault is raised in the memory stage. For each of these, the offending instruction is rewritten in place into the PC-saving branch. Every younger instruction in an earlier stage becomes a no-op, and fetch is steered to the trap vector. An asynchronous interrupt request does not discard anything. It rewrites only the instruction being fetched into the PC-saving branch, so the handler resumes at the saved value minus 4. An interrupt is taken only in a cycle without a stall and without a synchronous event. Until then it is held pending. The controller also supplies the 32-bit synthetic branch word that the stage multiplexers insert.

Top module: `trap_annul_ctrl`

## Requirements
- R1: After reset, with all event inputs low, no interrupt is pending: pcSel is 0 and every stage select is 0 (pass).
- R2: In a cycle with no event and no live interrupt, pcSel is 0 (sequential) and ifSel, rfSel, aluSel and memSel are all 0 (pass).
- R3: An undefined opcode in register read, with no ALU or memory fault, gives pcSel 1 (trap vector), rfSel 2 (save-PC branch) and ifSel 1 (no-op), and leaves aluSel and memSel at 0.
- R4: An ALU fault with no memory fault gives pcSel 1, aluSel 2, and rfSel and ifSel 1, with memSel 0.
- R5: A memory fault gives pcSel 1, memSel 2, and aluSel, rfSel and ifSel 1.
- R6: When several events fall in one cycle, the oldest stage wins: memory fault, then ALU fault, then undefined opcode, then interrupt. At most one stage select is 2 in any cycle.
- R7: A live interrupt in a cycle without stall and without a synchronous event gives pcSel 2 (interrupt vector) and ifSel 2, with rfSel, aluSel and memSel at 0.
- R8: An interrupt request seen while stall is high is not taken in that cycle. It is held and taken in the first later cycle with stall low and no synchronous event, even if the request line has fallen by then.
- R9: An interrupt displaced by a synchronous event stays pending and is taken at the next eligible cycle.
- R10: Taking an interrupt clears the pending state. Without a new request, the cycle after a take is an ordinary cycle.
- R11: saveInsn is constant. Bits 31:26 hold opcode 0x1D, bits 25:21 hold 30 (exception pointer), bits 20:16 hold 31 (the always-zero test register) and bits 15:0 hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| illegalRf | input | 1 | Undefined opcode decoded in register read |
| faultAlu | input | 1 | Arithmetic fault in the ALU stage |
| faultMem | input | 1 | Memory fault in the memory stage |
| irqReq | input | 1 | Interrupt request |
| stall | input | 1 | Pipeline stall (load interlock) |
| pcSel | output | 2 | Next fetch source: 0 sequential, 1 trap vector, 2 interrupt vector |
| ifSel | output | 2 | Fetch-stage select: 0 pass, 1 no-op, 2 save-PC branch |
| rfSel | output | 2 | Register-read select, same coding |
| aluSel | output | 2 | ALU-stage select, same coding |
| memSel | output | 2 | Memory-stage select, same coding |
| saveInsn | output | 32 | Synthetic PC-saving branch word |

## Verification
The hard cases are cycles in which two events coincide. The first is an interrupt arriving together with an undefined opcode or a fault, where the interrupt must give way and stay pending. The second is an interrupt arriving during a stall, where it must survive until the stall clears. Directed sequences set these up deliberately. One sequence raises the request for a single cycle inside a stall and then drops it. Another raises a memory fault, an ALU fault and an undefined opcode in the same cycle. A long pseudo-random run then mixes all five inputs. A behavioural model tracks the pending interrupt on its own, and the outputs are compared against it on every cycle.

// File: rtl/trap_annul_pkg.sv
package trap_annul_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PASS = 2'd0,
    SEL_NOP  = 2'd1,
    SEL_SAVE = 2'd2
  } stageSel_e;

  typedef enum logic [SEL_W-1:0] {
    PC_NEXT = 2'd0,
    PC_TRAP = 2'd1,
    PC_IRQ  = 2'd2
  } pcSel_e;

  // one strobe per winning event; at most one is high
  typedef struct packed {
    logic memTake;
    logic aluTake;
    logic illTake;
    logic irqTake;
  } evtStrobe_t;
endpackage

// File: rtl/trap_annul_ctl.sv
module trap_annul_ctl
  import trap_annul_pkg::*;
(
  input  logic       illegalRf,
  input  logic       faultAlu,
  input  logic       faultMem,
  input  logic       irqLive,
  input  logic       stall,
  output evtStrobe_t strobe
);
  logic anySync;

  assign anySync = faultMem | faultAlu | illegalRf;

  // oldest stage first; the interrupt yields to everything and to stall
  always_comb begin
    strobe         = '0;
    strobe.memTake = faultMem;
    strobe.aluTake = faultAlu & ~faultMem;
    strobe.illTake = illegalRf & ~faultAlu & ~faultMem;
    strobe.irqTake = irqLive & ~stall & ~anySync;
  end
endmodule

// File: rtl/trap_annul_dp.sv
module trap_annul_dp
  import trap_annul_pkg::*;
#(
  parameter logic [OPC_W-1:0] BR_OPC   = 6'h1D,
  parameter int               XP_REG   = 30,
  parameter int               ZERO_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  evtStrobe_t        strobe,
  output logic              irqLive,
  output logic [SEL_W-1:0]  pcSel,
  output logic [SEL_W-1:0]  ifSel,
  output logic [SEL_W-1:0]  rfSel,
  output logic [SEL_W-1:0]  aluSel,
  output logic [SEL_W-1:0]  memSel,
  output logic [INSN_W-1:0] saveInsn
);
  localparam int LIT_W = INSN_W - OPC_W - 2*REG_W;

  logic irqPend;

  assign irqLive = irqReq | irqPend;

  always_ff @(posedge clk) begin
    if (!rstN) irqPend <= 1'b0;
    else       irqPend <= irqLive & ~strobe.irqTake;
  end

  always_comb begin
    pcSel  = PC_NEXT;
    ifSel  = SEL_PASS;
    rfSel  = SEL_PASS;
    aluSel = SEL_PASS;
    memSel = SEL_PASS;
    if (strobe.memTake) begin
      pcSel  = PC_TRAP;
      memSel = SEL_SAVE;
      aluSel = SEL_NOP;
      rfSel  = SEL_NOP;
      ifSel  = SEL_NOP;
    end else if (strobe.aluTake) begin
      pcSel  = PC_TRAP;
      aluSel = SEL_SAVE;
      rfSel  = SEL_NOP;
      ifSel  = SEL_NOP;
    end else if (strobe.illTake) begin
      pcSel  = PC_TRAP;
      rfSel  = SEL_SAVE;
      ifSel  = SEL_NOP;
    end else if (strobe.irqTake) begin
      pcSel  = PC_IRQ;
      ifSel  = SEL_SAVE;
    end
  end

  assign saveInsn = {BR_OPC, REG_W'(XP_REG), REG_W'(ZERO_REG), {LIT_W{1'b0}}};
endmodule

// File: rtl/trap_annul_ctrl.sv
module trap_annul_ctrl
  import trap_annul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        illegalRf,
  input  logic        faultAlu,
  input  logic        faultMem,
  input  logic        irqReq,
  input  logic        stall,
  output logic [1:0]  pcSel,
  output logic [1:0]  ifSel,
  output logic [1:0]  rfSel,
  output logic [1:0]  aluSel,
  output logic [1:0]  memSel,
  output logic [31:0] saveInsn
);
  evtStrobe_t strobe;
  logic       irqLive;

  trap_annul_ctl ctl_i (
    .illegalRf(illegalRf), .faultAlu(faultAlu), .faultMem(faultMem),
    .irqLive(irqLive), .stall(stall), .strobe(strobe)
  );

  trap_annul_dp dp_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .strobe(strobe),
    .irqLive(irqLive), .pcSel(pcSel), .ifSel(ifSel), .rfSel(rfSel),
    .aluSel(aluSel), .memSel(memSel), .saveInsn(saveInsn)
  );
endmodule

// File: rtl/trap_annul_ctrl_chk.sv
module trap_annul_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       illegalRf,
  input logic       faultAlu,
  input logic       faultMem,
  input logic       irqReq,
  input logic       stall,
  input logic [1:0] pcSel,
  input logic [1:0] ifSel,
  input logic [1:0] rfSel,
  input logic [1:0] aluSel,
  input logic [1:0] memSel
);
  logic noSync;
  assign noSync = !illegalRf && !faultAlu && !faultMem;

  a_r5_mem_flush: assert property (@(posedge clk) disable iff (!rstN)
    faultMem |-> (memSel == 2'd2 && aluSel == 2'd1 && rfSel == 2'd1 && ifSel == 2'd1 && pcSel == 2'd1));

  a_r4_alu_flush: assert property (@(posedge clk) disable iff (!rstN)
    (faultAlu && !faultMem) |-> (aluSel == 2'd2 && memSel == 2'd0 && rfSel == 2'd1 && pcSel == 2'd1));

  a_r3_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (illegalRf && !faultAlu && !faultMem) |-> (rfSel == 2'd2 && ifSel == 2'd1 && aluSel == 2'd0 && pcSel == 2'd1));

  a_r6_one_save: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memSel == 2'd2, aluSel == 2'd2, rfSel == 2'd2, ifSel == 2'd2}));

  a_r8_held_through_stall: assert property (@(posedge clk) disable iff (!rstN)
    (noSync && !stall && $past(irqReq && stall && rstN)) |-> (pcSel == 2'd2 && ifSel == 2'd2));

  a_r10_pend_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == 2'd2) |=> (pcSel != 2'd2 || irqReq));

  a_r7_stall_blocks_irq: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (pcSel != 2'd2));
endmodule

bind trap_annul_ctrl trap_annul_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .illegalRf(illegalRf), .faultAlu(faultAlu),
  .faultMem(faultMem), .irqReq(irqReq), .stall(stall), .pcSel(pcSel),
  .ifSel(ifSel), .rfSel(rfSel), .aluSel(aluSel), .memSel(memSel)
);

// File: tb/trap_annul_ctrl_tb_top.sv
module trap_annul_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic illegalRf = 1'b0, faultAlu = 1'b0, faultMem = 1'b0, irqReq = 1'b0, stall = 1'b0;
  logic [1:0] pcSel, ifSel, rfSel, aluSel, memSel;
  logic [31:0] saveInsn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  bit modelPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_annul_ctrl dut_i (
    .clk(clk), .rstN(rstN), .illegalRf(illegalRf), .faultAlu(faultAlu),
    .faultMem(faultMem), .irqReq(irqReq), .stall(stall), .pcSel(pcSel),
    .ifSel(ifSel), .rfSel(rfSel), .aluSel(aluSel), .memSel(memSel),
    .saveInsn(saveInsn)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, compare against the model, then advance the model
  task automatic step(input bit ill, input bit alu, input bit mem, input bit irq, input bit stl, input string tagIn);
    bit live;
    logic [1:0] ePc, eIf, eRf, eAlu, eMem;
    string tag;
    @(negedge clk);
    illegalRf = ill; faultAlu = alu; faultMem = mem; irqReq = irq; stall = stl;
    #1;
    live = irq | modelPend;
    ePc = 0; eIf = 0; eRf = 0; eAlu = 0; eMem = 0; tag = tagIn;
    if (mem)              begin ePc = 1; eMem = 2; eAlu = 1; eRf = 1; eIf = 1; if (tag == "") tag = "R5"; end
    else if (alu)         begin ePc = 1; eAlu = 2; eRf = 1; eIf = 1;           if (tag == "") tag = "R4"; end
    else if (ill)         begin ePc = 1; eRf = 2; eIf = 1;                     if (tag == "") tag = "R3"; end
    else if (live && !stl) begin ePc = 2; eIf = 2;                             if (tag == "") tag = "R7"; end
    else if (tag == "") tag = "R2";
    cmp(tag, "pcSel",  {30'd0, pcSel},  {30'd0, ePc});
    cmp(tag, "ifSel",  {30'd0, ifSel},  {30'd0, eIf});
    cmp(tag, "rfSel",  {30'd0, rfSel},  {30'd0, eRf});
    cmp(tag, "aluSel", {30'd0, aluSel}, {30'd0, eAlu});
    cmp(tag, "memSel", {30'd0, memSel}, {30'd0, eMem});
    modelPend = live && !(ePc == 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "pcSel in reset", {30'd0, pcSel}, 32'd0);
    rstN = 1'b1;
    // R1: first cycle out of reset is idle
    step(0,0,0,0,0, "R1");
    // R11: synthetic branch word
    cmp("R11", "saveInsn", saveInsn, {6'h1D, 5'd30, 5'd31, 16'd0});
    step(0,0,0,0,0, "R2");
    step(1,0,0,0,0, "R3");
    step(0,1,0,0,0, "R4");
    step(0,0,1,0,0, "R5");
    step(1,1,1,1,0, "R6");   // all at once: memory wins, irq pends
    step(0,0,0,0,0, "R9");   // pending irq taken
    step(0,0,0,0,0, "R10");  // cleared
    step(1,1,0,0,0, "R6");
    step(0,0,0,1,0, "R7");
    step(0,0,0,0,0, "R10");
    step(0,0,0,1,1, "R8");   // request only during stall
    step(0,0,0,0,1, "R8");
    step(0,0,0,0,0, "R8");   // taken now
    step(0,0,0,0,0, "R10");
    step(0,0,0,1,0, "R9");   // fresh irq vs illegal below
    step(1,0,0,1,0, "R9");
    step(0,0,0,0,0, "R7");
    step(0,1,0,1,1, "R9");   // stall and fault together
    step(0,0,0,0,1, "R8");
    step(0,0,0,0,0, "R8");
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] == 3'd0, lfsr[5:3] == 3'd1, lfsr[8:6] == 3'd2,
           lfsr[11:9] == 3'd3, lfsr[13:12] == 2'd0, "");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule